// File: doc/BRIEF.md
# Multichip Clock Synchronization Sequencer

This controller steps a group of identical transceiver devices through a two-stage clock alignment. It issues enable-mask writes on a request/acknowledge write port, and drives one shared sync strobe, timed to the reference clock, to every device. The first strobe aligns the baseband PLLs to the common reference. A change of enable bits then retargets the devices. The second strobe aligns the digital clock dividers and data clocks. A final write disarms the synchronization logic, so that a stray strobe has no effect.

A start request begins the run. The reference mode input gives the devices' internal PLL reference ratio: 1x, 2x, one-half or one-quarter. The divided ratios do not support synchronization. A start in one of those modes is refused and raises the error flag. Between each strobe and the following write there is a programmable settle interval, counted in reference cycles. The strobe is launched from a falling-edge register. Its rising and falling transitions therefore land half a reference period after a rising edge, away from both edges at which a device may capture it.

Top module: `mcs_sequencer`

## Requirements
- R1: After reset, wr_req_o, sync_o, busy_o, done_o and error_o are all low.
- R2: When idle, start_i with ref_mode_i of 0 (1x) or 1 (2x) starts a run: busy_o rises and error_o clears. With ref_mode_i of 2 (one-half) or 3 (one-quarter), error_o is set, busy_o stays low and no write is issued.
- R3: A run issues exactly four writes, in this order. The mask bits are bit 0 PLL-sync, bit 1 baseband-sync, bit 2 digital-sync and bit 3 reference-scale. The masks are 4'b0011, 4'b1011, 4'b1110 and 4'b1000.
- R4: A write request stays high, with its data unchanged, until wr_ack_i is sampled high. The run does not advance past a write before that acknowledge.
- R5: Exactly two sync pulses are driven. The first follows the acknowledge of the second write, and the second follows the acknowledge of the third write. Each pulse is high for PULSE_W reference cycles.
- R6: Every transition of sync_o occurs on a falling edge of clk_i. sync_o never changes at a rising edge.
- R7: After each pulse ends, settle_i whole cycles pass with no write request and no pulse. The next write request then follows.
- R8: start_i while busy has no effect on the write sequence, the pulses or error_o.
- R9: done_o is high for exactly one cycle, in the cycle after the final write is acknowledged. busy_o is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a synchronization run |
| ref_mode_i | input | 2 | Internal PLL reference ratio: 0 = 1x, 1 = 2x, 2 = half, 3 = quarter |
| settle_i | input | SETTLE_W | Settle cycles after each sync pulse |
| wr_req_o | output | 1 | Enable-mask write request |
| wr_data_o | output | 4 | Enable mask to be written |
| wr_ack_i | input | 1 | Write accepted |
| sync_o | output | 1 | Shared sync strobe, launched on the falling edge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| error_o | output | 1 | Last start was refused for an unsupported mode |

## Verification
On every cycle the assertions check the following: the write handshake stays stable while it is unacknowledged, and refused starts leave the block idle with error set. They also check that a start while busy cannot end a run, that the strobe never overlaps a write request and never runs longer than PULSE_W, and that done is a single cycle with busy low. The order and values of the four masks, the placement of each pulse relative to the writes, the exact settle gap and the falling-edge launch can only be shown by the bench. It sweeps both supported modes, settle values 0 to 5 and acknowledge latencies 0 to 2. It samples the strobe on both halves of each cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int MASK_W   = 4;
  localparam int EN_PLL   = 0;
  localparam int EN_BB    = 1;
  localparam int EN_DIG   = 2;
  localparam int EN_SCALE = 3;

  typedef enum logic [1:0] {
    REF_X1   = 2'd0,
    REF_X2   = 2'd1,
    REF_DIV2 = 2'd2,
    REF_DIV4 = 2'd3
  } ref_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARM,
    ST_SCALE,
    ST_PULSE1,
    ST_SETTLE1,
    ST_RETARGET,
    ST_PULSE2,
    ST_SETTLE2,
    ST_DISARM
  } seq_state_e;

  // Only undivided internal references may be synchronized
  function automatic logic mode_supported(input logic [1:0] mode);
    return (mode == REF_X1) || (mode == REF_X2);
  endfunction

  function automatic logic is_write_step(input seq_state_e s);
    return (s == ST_ARM) || (s == ST_SCALE) || (s == ST_RETARGET) || (s == ST_DISARM);
  endfunction

  function automatic logic [MASK_W-1:0] step_mask(input seq_state_e s);
    logic [MASK_W-1:0] m;
    m = '0;
    case (s)
      ST_ARM: begin
        m[EN_PLL] = 1'b1;
        m[EN_BB]  = 1'b1;
      end
      ST_SCALE: begin
        m[EN_PLL]   = 1'b1;
        m[EN_BB]    = 1'b1;
        m[EN_SCALE] = 1'b1;
      end
      ST_RETARGET: begin
        m[EN_BB]    = 1'b1;
        m[EN_DIG]   = 1'b1;
        m[EN_SCALE] = 1'b1;
      end
      ST_DISARM: begin
        m[EN_SCALE] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mcs_sync_pulse.sv
module mcs_sync_pulse #(
  parameter int PULSE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o,
  output logic last_o,
  output logic sync_o
);
  localparam int PW_EFF = (PULSE_W < 1) ? 1 : PULSE_W;
  localparam int CW     = (PW_EFF < 2) ? 1 : $clog2(PW_EFF);

  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          launch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (fire_i) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(PW_EFF - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  // Half-cycle launch keeps both strobe transitions clear of rising edges
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) launch_q <= 1'b0;
    else         launch_q <= active_q;
  end

  assign active_o = active_q;
  assign last_o   = active_q && (cnt_q == '0);
  assign sync_o   = launch_q;
endmodule

// File: rtl/mcs_settle_timer.sv
module mcs_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] value_i,
  output logic                zero_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= value_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int PULSE_W  = 2,
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          ref_mode_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                wr_req_o,
  output logic [MASK_W-1:0]   wr_data_o,
  input  logic                wr_ack_i,
  output logic                sync_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                error_o
);
  seq_state_e state_q, state_d;

  // Named internal events, used by the bound checker
  logic idle;
  logic start_accept;
  logic start_refuse;
  logic step_ack;
  logic pulse_fire;
  logic pulse_active;
  logic pulse_last;
  logic settle_zero;
  logic done_q;
  logic error_q;

  assign idle         = (state_q == ST_IDLE);
  assign start_accept = idle && start_i && mode_supported(ref_mode_i);
  assign start_refuse = idle && start_i && !mode_supported(ref_mode_i);
  assign wr_req_o     = is_write_step(state_q);
  assign wr_data_o    = step_mask(state_q);
  assign step_ack     = wr_req_o && wr_ack_i;
  assign pulse_fire   = step_ack && ((state_q == ST_SCALE) || (state_q == ST_RETARGET));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_accept) state_d = ST_ARM;
      ST_ARM:      if (step_ack)     state_d = ST_SCALE;
      ST_SCALE:    if (step_ack)     state_d = ST_PULSE1;
      ST_PULSE1:   if (pulse_last)   state_d = ST_SETTLE1;
      ST_SETTLE1:  if (settle_zero)  state_d = ST_RETARGET;
      ST_RETARGET: if (step_ack)     state_d = ST_PULSE2;
      ST_PULSE2:   if (pulse_last)   state_d = ST_SETTLE2;
      ST_SETTLE2:  if (settle_zero)  state_d = ST_DISARM;
      ST_DISARM:   if (step_ack)     state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= step_ack && (state_q == ST_DISARM);
      if (start_refuse)      error_q <= 1'b1;
      else if (start_accept) error_q <= 1'b0;
    end
  end

  mcs_sync_pulse #(
    .PULSE_W (PULSE_W)
  ) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (pulse_fire),
    .active_o (pulse_active),
    .last_o   (pulse_last),
    .sync_o   (sync_o)
  );

  mcs_settle_timer #(
    .SETTLE_W (SETTLE_W)
  ) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pulse_last),
    .value_i (settle_i),
    .zero_o  (settle_zero)
  );

  assign busy_o  = !idle;
  assign done_o  = done_q;
  assign error_o = error_q;
endmodule

// File: rtl/mcs_sequencer_chk.sv
module mcs_sequencer_chk #(
  parameter int PULSE_W = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] ref_mode_i,
  input logic       wr_req_o,
  input logic [3:0] wr_data_o,
  input logic       wr_ack_i,
  input logic       sync_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o,
  input logic       pulse_active
);
  int sync_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sync_run <= 0;
    else if (sync_o) sync_run <= sync_run + 1;
    else             sync_run <= 0;
  end

  a_r4_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_data_o));

  a_r2_refuse_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && ref_mode_i[1] |=> error_o && !busy_o && !wr_req_o);

  a_r8_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !wr_ack_i |=> busy_o);

  a_r5_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> sync_run < PULSE_W);

  a_r7_quiet_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o || pulse_active) |-> !wr_req_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(wr_req_o && wr_ack_i));
endmodule

bind mcs_sequencer mcs_sequencer_chk #(
  .PULSE_W (PULSE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ref_mode_i   (ref_mode_i),
  .wr_req_o     (wr_req_o),
  .wr_data_o    (wr_data_o),
  .wr_ack_i     (wr_ack_i),
  .sync_o       (sync_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .error_o      (error_o),
  .pulse_active (pulse_active)
);

// File: tb/test_mcs_sequencer.sv
module test_mcs_sequencer;
  localparam int PW = 2;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [SW-1:0] settle = '0;
  logic          wr_req;
  logic [3:0]    wr_data;
  logic          wr_ack = 1'b0;
  logic          sync;
  logic          busy;
  logic          done;
  logic          err;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mcs_sequencer #(.PULSE_W(PW), .SETTLE_W(SW)) i_mcs_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ref_mode_i(mode),
    .settle_i(settle), .wr_req_o(wr_req), .wr_data_o(wr_data),
    .wr_ack_i(wr_ack), .sync_o(sync), .busy_o(busy), .done_o(done),
    .error_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Masks from the bit positions: 0 PLL, 1 baseband, 2 digital, 3 scale
  function automatic int exp_mask(input int idx);
    case (idx)
      0: return (1 << 0) | (1 << 1);
      1: return (1 << 0) | (1 << 1) | (1 << 3);
      2: return (1 << 1) | (1 << 2) | (1 << 3);
      3: return (1 << 3);
      default: return -1;
    endcase
  endfunction

  task automatic run_good(input int md, input int st, input int lat, input bit inject);
    int  wr_idx = 0, held = 0, data0 = 0, bad_hold = 0;
    int  pulses = 0, plen = 0, gap = 0, rises_mid = 0, edge_bad = 0;
    bit  prev_req = 0, prev_ack = 0, prev_sync = 0, mid_prev = 0, gap_on = 0;
    bit  seen_done = 0, s_sync, s_req, mid;
    int  s_data;
    mode   = 2'(md);
    settle = SW'(st);
    start  = 1'b1;
    step();
    start  = 1'b0;
    check(busy == 1'b1, "R2 busy on accepted start", int'(busy), 1);
    check(err == 1'b0, "R2 error cleared on accepted start", int'(err), 0);
    for (int it = 0; it < 400; it++) begin
      s_sync = sync;
      s_req  = wr_req;
      s_data = int'(wr_data);
      if (it > 0 && s_sync != mid_prev) edge_bad++;
      // strobe rise / fall bookkeeping
      if (s_sync && !prev_sync) begin
        check(wr_idx == 2 + pulses, "R5 pulse placement after writes", wr_idx, 2 + pulses);
        plen = 0;
      end
      if (s_sync) plen++;
      if (!s_sync && prev_sync) begin
        check(plen == PW, "R5 pulse width", plen, PW);
        pulses++;
        gap_on = 1;
        gap = 0;
      end
      if (gap_on) begin
        if (s_req || s_sync) begin
          check(gap == st, "R7 settle gap", gap, st);
          gap_on = 0;
        end else gap++;
      end
      // write handshake
      wr_ack = 1'b0;
      if (s_req) begin
        if (!prev_req || prev_ack) begin
          held = 0;
          data0 = s_data;
        end else begin
          held++;
          if (s_data != data0) bad_hold++;
        end
        if (held == lat) begin
          wr_ack = 1'b1;
          check(s_data == exp_mask(wr_idx), "R3 write mask order", s_data, exp_mask(wr_idx));
          wr_idx++;
        end
      end
      // R8: start requests while busy, with a refused mode as well
      start = 1'b0;
      if (inject && gap_on && !s_req) begin
        start = 1'b1;
        mode  = 2'((it % 2 == 0) ? 2 : md);
      end
      if (seen_done) begin
        check(done == 1'b0, "R9 done lasts one cycle", int'(done), 0);
        mode = 2'(md);
        break;
      end
      if (done) begin
        seen_done = 1;
        check(wr_idx == 4, "R9 done after final write", wr_idx, 4);
        check(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        check(err == 1'b0, "R8 error untouched while busy", int'(err), 0);
      end
      prev_req  = s_req;
      prev_ack  = wr_ack;
      prev_sync = s_sync;
      #4;
      mid = sync;
      if (mid != s_sync) begin
        if (mid) rises_mid++;
      end
      mid_prev = mid;
      step();
    end
    wr_ack = 1'b0;
    start  = 1'b0;
    check(seen_done, "R9 run completes", int'(seen_done), 1);
    check(pulses == 2, "R5 two pulses", pulses, 2);
    check(rises_mid == 2, "R6 rises on falling edge", rises_mid, 2);
    check(edge_bad == 0, "R6 no change at rising edge", edge_bad, 0);
    check(bad_hold == 0, "R4 request data held", bad_hold, 0);
    check(wr_idx == 4, "R4 writes advanced only by ack", wr_idx, 4);
  endtask

  task automatic run_bad(input int md);
    int reqs = 0;
    mode  = 2'(md);
    start = 1'b1;
    step();
    start = 1'b0;
    check(err == 1'b1, "R2 error on refused mode", int'(err), 1);
    check(busy == 1'b0, "R2 busy stays low on refused mode", int'(busy), 0);
    for (int k = 0; k < 6; k++) begin
      if (wr_req || sync) reqs++;
      step();
    end
    check(reqs == 0, "R2 no activity after refusal", reqs, 0);
    check(err == 1'b1, "R2 error held", int'(err), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    step();
    check({wr_req, sync, busy, done, err} == 5'b0, "R1 reset outputs",
          int'({wr_req, sync, busy, done, err}), 0);
    rst_n = 1'b1;
    step();
    check({wr_req, sync, busy, done, err} == 5'b0, "R1 idle after reset",
          int'({wr_req, sync, busy, done, err}), 0);
    for (int md = 0; md < 2; md++)
      for (int st = 0; st < 6; st++)
        for (int lat = 0; lat < 3; lat++) begin
          run_good(md, st, lat, st >= 2);
          step();
        end
    for (int bm = 2; bm < 4; bm++) begin
      run_bad(bm);
      run_good(bm - 2, 1, 1, 1'b0);
      step();
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule